// File: doc/BRIEF.md
# Page-List Scatter-Gather DMA Engine

This bus-master engine moves a byte stream between a device-side FIFO and system memory. Memory is described either as one linear buffer or as a list of 4096-byte page base addresses that is itself held in memory. Software loads a byte count, a start offset inside the first page, and a base address. The base address points at the page list in list mode and at the buffer in linear mode. Software then writes a control word that carries the operation, the direction and the list-mode enable.

In list mode the engine reads one 32-bit list entry per page. It applies the start offset to the first page only and reads the next entry each time the byte address leaves a page. Memory-to-device transfers read whole words and hand their bytes to the device one at a time. Device-to-memory transfers pack incoming bytes into a word and write it with byte enables. A flush command writes out bytes still packed inside the engine when the device stops early. Memory is reached through a single-outstanding request/response port.

Top module: `sgdma_engine`

## Requirements
- R1: After reset, and one cycle after any control write with operation IDLE (0), the status flags are all clear, ACTIVE is 0, and no memory request or device handshake is offered.
- R2: Status bit 4 (ACTIVE) reads 1 exactly when the last control word written has a non-IDLE operation. Operation codes in control bits [1:0] are 0 IDLE, 1 START, 2 ABORT and 3 BLAST. Bit 2 set selects device-to-memory, and bit 3 enables list mode. Status bits [3:0] are BCMP, DONE, ABT and ERR, from bit 3 down to bit 0.
- R3: In list mode the first memory request reads the list entry at the base address. The first data byte is at that entry's page base plus the start offset.
- R4: When a list-mode transfer leaves a 4 KB page with bytes remaining, the next request reads the entry at base + 4 × page index before any further data access. Every page after the first is used from offset 0.
- R5: In linear mode no list entry is read, and bytes are addressed contiguously from base + offset, across 4 KB boundaries.
- R6: Memory-to-device bytes leave in ascending address order. The remaining count drops by one per byte. At zero, DONE is set and requests stop.
- R7: Device-to-memory bytes are written with byte enables so that only the addressed bytes change. A write is issued at each word end and after the last byte.
- R8: BLAST during a device-to-memory transfer writes any partially packed word to memory, then sets BCMP. The remaining count stays readable.
- R9: ABORT during a transfer removes any memory request by the next cycle, sets ABT and keeps the remaining count.
- R10: An error response sets ERR and halts the engine. It stays halted with no requests until IDLE is written.
- R11: Writes to count, offset and base are ignored unless the engine is idle.
- R12: START with a count of zero sets DONE and issues no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 control, 1 count, 2 offset, 3 base, 4 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request, held until a response |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word-aligned memory address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_rsp_valid | input | 1 | Response for the pending request |
| mem_rsp_err | input | 1 | Response carries a bus error |
| mem_rsp_data | input | 32 | Read data |
| dev_out_valid | output | 1 | Byte offered to the device |
| dev_out_data | output | 8 | Byte to the device |
| dev_out_ready | input | 1 | Device accepts the byte |
| dev_in_valid | input | 1 | Device offers a byte |
| dev_in_data | input | 8 | Byte from the device |
| dev_in_ready | output | 1 | Engine accepts the byte |

## Verification
The embedded properties check every cycle that a pending request holds its address until answered, and that ABORT and error responses drop requests on the next edge. They also check that an IDLE write clears every flag, that at most one completion flag is ever set, and that DONE only coexists with a zero count. The scenarios alone can show the order of list fetches against data accesses, the offset applied only to the first page, the byte stream contents, and the byte-enable extent of writes. They also cover the partial word that BLAST writes out and the register writes that are ignored while a transfer runs. A behavioural memory and byte stream model in the bench supplies those expected values.

// File: rtl/sgdma_engine.sv
module sgdma_engine #(
  parameter int AW = 32,
  parameter int CW = 24,
  parameter int PG = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic          mem_rsp_valid,
  input  logic          mem_rsp_err,
  input  logic [31:0]   mem_rsp_data,
  output logic          dev_out_valid,
  output logic [7:0]    dev_out_data,
  input  logic          dev_out_ready,
  input  logic          dev_in_valid,
  input  logic [7:0]    dev_in_data,
  output logic          dev_in_ready
);
  localparam int PW = AW - 2;
  localparam logic [1:0] OP_IDLE = 2'd0, OP_START = 2'd1, OP_ABORT = 2'd2, OP_BLAST = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RD, S_EMIT, S_FILL, S_WR, S_STOP} st_t;

  st_t           st;
  logic [1:0]    op;
  logic          to_mem, list_en, flush;
  logic          f_err, f_abt, f_done, f_bcmp;
  logic [CW-1:0] cnt;
  logic [PG-1:0] off;
  logic [AW-1:0] base, addr, waddr;
  logic [PW-1:0] pidx;
  logic [31:0]   rbuf, wbuf;
  logic [3:0]    wbe;

  wire       ctl_wr   = reg_we && reg_addr == 3'd0;
  wire [1:0] wop      = reg_wdata[1:0];
  wire       running  = st != S_IDLE && st != S_STOP;
  wire       rsp      = mem_req && mem_rsp_valid;
  wire [1:0] lane     = addr[1:0];
  wire       last     = cnt == CW'(1);
  wire       page_end = &addr[PG-1:0];

  assign mem_req       = st == S_FETCH || st == S_RD || st == S_WR;
  assign mem_we        = st == S_WR;
  assign mem_addr      = st == S_FETCH ? base + {pidx, 2'b00} :
                         st == S_WR    ? waddr : {addr[AW-1:2], 2'b00};
  assign mem_wdata     = wbuf;
  assign mem_be        = st == S_WR ? wbe : 4'b0000;
  assign dev_out_valid = st == S_EMIT;
  assign dev_out_data  = rbuf[8*lane +: 8];
  assign dev_in_ready  = st == S_FILL && !ctl_wr;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {28'd0, list_en, to_mem, op};
      3'd1:    reg_rdata = 32'(cnt);
      3'd2:    reg_rdata = 32'(off);
      3'd3:    reg_rdata = 32'(base);
      3'd4:    reg_rdata = {27'd0, op != OP_IDLE, f_bcmp, f_done, f_abt, f_err};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= OP_IDLE; to_mem <= 1'b0; list_en <= 1'b0; flush <= 1'b0;
      f_err <= 1'b0; f_abt <= 1'b0; f_done <= 1'b0; f_bcmp <= 1'b0;
      cnt <= '0; off <= '0; base <= '0; addr <= '0; waddr <= '0; pidx <= '0;
      rbuf <= '0; wbuf <= '0; wbe <= '0;
    end else begin
      if (ctl_wr) op <= wop;
      if (reg_we && st == S_IDLE) begin
        case (reg_addr)
          3'd0: begin to_mem <= reg_wdata[2]; list_en <= reg_wdata[3]; end
          3'd1: cnt  <= reg_wdata[CW-1:0];
          3'd2: off  <= reg_wdata[PG-1:0];
          3'd3: base <= reg_wdata[AW-1:0];
          default: ;
        endcase
      end
      if (ctl_wr && wop == OP_IDLE) begin
        st <= S_IDLE; flush <= 1'b0; wbe <= '0;
        f_err <= 1'b0; f_abt <= 1'b0; f_done <= 1'b0; f_bcmp <= 1'b0;
      end else if (ctl_wr && wop == OP_START && st == S_IDLE) begin
        pidx <= '0;
        addr <= base + AW'(off);
        if (cnt == '0) begin f_done <= 1'b1; st <= S_STOP; end
        else if (reg_wdata[3]) st <= S_FETCH;
        else st <= reg_wdata[2] ? S_FILL : S_RD;
      end else if (ctl_wr && wop == OP_ABORT && running) begin
        f_abt <= 1'b1; st <= S_STOP;
      end else if (ctl_wr && wop == OP_BLAST && st == S_FILL) begin
        if (wbe != 4'b0000) begin flush <= 1'b1; st <= S_WR; end
        else begin f_bcmp <= 1'b1; st <= S_STOP; end
      end else begin
        case (st)
          S_FETCH: if (rsp) begin
            if (mem_rsp_err) begin f_err <= 1'b1; st <= S_STOP; end
            else begin
              addr <= {mem_rsp_data[AW-1:PG], pidx == '0 ? off : PG'(0)};
              pidx <= pidx + 1'b1;
              st   <= to_mem ? S_FILL : S_RD;
            end
          end
          S_RD: if (rsp) begin
            if (mem_rsp_err) begin f_err <= 1'b1; st <= S_STOP; end
            else begin rbuf <= mem_rsp_data; st <= S_EMIT; end
          end
          S_EMIT: if (dev_out_ready) begin
            addr <= addr + 1'b1;
            cnt  <= cnt - 1'b1;
            if (last) begin f_done <= 1'b1; st <= S_STOP; end
            else if (list_en && page_end) st <= S_FETCH;
            else if (lane == 2'd3) st <= S_RD;
          end
          S_FILL: if (dev_in_valid) begin
            wbuf[8*lane +: 8] <= dev_in_data;
            wbe[lane] <= 1'b1;
            waddr <= {addr[AW-1:2], 2'b00};
            addr  <= addr + 1'b1;
            cnt   <= cnt - 1'b1;
            if (last || lane == 2'd3) st <= S_WR;
          end
          S_WR: if (rsp) begin
            wbe <= '0;
            if (mem_rsp_err) begin f_err <= 1'b1; st <= S_STOP; end
            else if (flush) begin flush <= 1'b0; f_bcmp <= 1'b1; st <= S_STOP; end
            else if (cnt == '0) begin f_done <= 1'b1; st <= S_STOP; end
            else if (list_en && addr[PG-1:0] == '0) st <= S_FETCH;
            else st <= S_FILL;
          end
          default: ;
        endcase
      end
    end
  end

  // Requests are held unchanged until answered (R6).
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rsp_valid && !ctl_wr) |=> (mem_req && $stable(mem_addr)));

  p_done_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    f_done |-> cnt == '0);

  p_abort_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wop == OP_ABORT && running) |=> (!mem_req && f_abt));

  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({f_err, f_abt, f_done, f_bcmp}));

  p_err_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp && mem_rsp_err && !ctl_wr) |=> (f_err && !mem_req));

  p_stop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (f_err || f_abt || f_done || f_bcmp) |-> (!mem_req && !dev_out_valid && !dev_in_ready));

  p_idle_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wop == OP_IDLE) |=> (!f_err && !f_abt && !f_done && !f_bcmp && !mem_req && !dev_in_ready));
endmodule

// File: tb/sim_sgdma_engine.sv
`timescale 1ns/1ps
module sim_sgdma_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0] mem_be;
  logic rsp_v = 1'b0, rsp_e = 1'b0;
  logic [31:0] rsp_d = '0;
  logic dev_out_valid, dev_out_ready = 1'b1;
  logic [7:0] dev_out_data;
  logic dev_in_valid = 1'b0, dev_in_ready;
  logic [7:0] dev_in_data = '0;

  always #2.5 clk = ~clk;

  sgdma_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rsp_valid(rsp_v), .mem_rsp_err(rsp_e),
    .mem_rsp_data(rsp_d), .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
    .dev_out_ready(dev_out_ready), .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
    .dev_in_ready(dev_in_ready));

  logic [31:0] mem [0:4095];
  logic [31:0] got_req [$];
  logic [7:0]  exp_b [$];
  int dptr = 0, dchk = 0, derr = 0;
  int checks = 0, errors = 0;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return 8'(a ^ (a >> 5) ^ 32'h5A);
  endfunction

  // Behavioural memory: one response a cycle after each request, errors above 16 KB.
  always @(posedge clk) begin
    if (!rst_n) begin
      rsp_v <= 1'b0;
      for (int w = 0; w < 4096; w++)
        mem[w] = {pat(32'(4*w+3)), pat(32'(4*w+2)), pat(32'(4*w+1)), pat(32'(4*w))};
      mem[32'h100 >> 2] = 32'h3000;
      mem[32'h104 >> 2] = 32'h1000;
      mem[32'h200 >> 2] = 32'h2000;
    end else if (mem_req && !rsp_v) begin
      rsp_v <= 1'b1;
      got_req.push_back(mem_addr);
      if (mem_addr >= 32'h4000) rsp_e <= 1'b1;
      else begin
        rsp_e <= 1'b0;
        if (mem_we)
          for (int l = 0; l < 4; l++)
            if (mem_be[l]) mem[mem_addr[13:2]][8*l +: 8] = mem_wdata[8*l +: 8];
        rsp_d <= mem[mem_addr[13:2]];
      end
    end else rsp_v <= 1'b0;
  end

  // Device byte stream compared with the expected stream on every clock (R6).
  always @(negedge clk) begin
    if (rst_n && dev_out_valid && dev_out_ready) begin
      dchk++;
      if (dptr >= exp_b.size()) begin
        derr++; $display("FAIL R6 unexpected device byte act %0h exp none", dev_out_data);
      end else begin
        if (dev_out_data !== exp_b[dptr]) begin
          derr++; $display("FAIL R6 byte %0d act %0h exp %0h", dptr, dev_out_data, exp_b[dptr]);
        end
        dptr++;
      end
    end
  end

  initial begin
    #1000000;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks + dchk + 1, errors + derr + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s act %0h exp %0h", r, act, exp); end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_stat(input logic [31:0] mask);
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      rd(3'd4, v);
      if ((v & mask) != 0) break;
      @(negedge clk);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); dev_in_valid = 1'b1; dev_in_data = b;
    for (int i = 0; i < 1000 && !dev_in_ready; i++) @(negedge clk);
    @(negedge clk); dev_in_valid = 1'b0;
  endtask

  function automatic logic [7:0] mb(input logic [31:0] a);
    return mem[a[13:2]][8*a[1:0] +: 8];
  endfunction

  task automatic chk_reqs(input int mark, input logic [31:0] e [$], input string r);
    chk(got_req.size() - mark == e.size(), {r, " request count"}, 32'(got_req.size() - mark), 32'(e.size()));
    for (int i = 0; i < e.size() && mark + i < got_req.size(); i++)
      chk(got_req[mark+i] == e[i], {r, " request address"}, got_req[mark+i], e[i]);
  endtask

  initial begin
    logic [31:0] v;
    int mark;
    logic [31:0] e [$];
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd4, v); chk(v == 0, "R1 reset status", v, 0);
    rd(3'd0, v); chk(v == 0, "R2 reset control", v, 0);
    chk(!mem_req && !dev_out_valid && !dev_in_ready, "R1 reset quiet", {mem_req, dev_out_valid, dev_in_ready}, 0);

    // R3 R4 R6: list mode read across a page, out-of-order pages
    for (int a = 32'h3FFA; a <= 32'h3FFF; a++) exp_b.push_back(pat(32'(a)));
    for (int a = 32'h1000; a <= 32'h1005; a++) exp_b.push_back(pat(32'(a)));
    mark = got_req.size();
    wr(3'd1, 12); wr(3'd2, 32'hFFA); wr(3'd3, 32'h100); wr(3'd0, 32'h9);
    wait_stat(32'h4);
    rd(3'd4, v); chk(v == 32'h14, "R6 done and R2 active", v, 32'h14);
    rd(3'd1, v); chk(v == 0, "R6 count exhausted", v, 0);
    chk(dptr == exp_b.size(), "R6 all bytes delivered", dptr, exp_b.size());
    e = '{32'h100, 32'h3FF8, 32'h3FFC, 32'h104, 32'h1000, 32'h1004};
    chk_reqs(mark, e, "R3 R4");

    // R1 IDLE clears
    wr(3'd0, 32'h0);
    rd(3'd4, v); chk(v == 0, "R1 idle clears status", v, 0);

    // R7 list mode write with byte enables
    mark = got_req.size();
    wr(3'd1, 9); wr(3'd2, 32'h7FE); wr(3'd3, 32'h200); wr(3'd0, 32'hD);
    for (int i = 0; i < 9; i++) push(8'(8'hA0 + i));
    wait_stat(32'h4);
    for (int i = 0; i < 9; i++)
      chk(mb(32'h27FE + i) == 8'(8'hA0 + i), "R7 written byte", mb(32'h27FE + i), 8'hA0 + i);
    chk(mb(32'h27FD) == pat(32'h27FD), "R7 lower neighbour kept", mb(32'h27FD), pat(32'h27FD));
    chk(mb(32'h2807) == pat(32'h2807), "R7 upper neighbour kept", mb(32'h2807), pat(32'h2807));
    e = '{32'h200, 32'h27FC, 32'h2800, 32'h2804};
    chk_reqs(mark, e, "R7 R3");
    wr(3'd0, 32'h0);

    // R8 R5: linear write ended early, then BLAST
    mark = got_req.size();
    wr(3'd1, 10); wr(3'd2, 0); wr(3'd3, 32'h1800); wr(3'd0, 32'h5);
    for (int i = 0; i < 6; i++) push(8'(8'hB0 + i));
    repeat (5) @(negedge clk);
    chk(mb(32'h1804) == pat(32'h1804), "R8 partial word held", mb(32'h1804), pat(32'h1804));
    rd(3'd4, v); chk(v == 32'h10, "R8 no flag before blast", v, 32'h10);
    wr(3'd0, 32'h7);
    wait_stat(32'h8);
    rd(3'd4, v); chk(v == 32'h18, "R8 blast complete", v, 32'h18);
    chk(mb(32'h1804) == 8'hB4 && mb(32'h1805) == 8'hB5, "R8 flushed bytes", {mb(32'h1804), mb(32'h1805)}, 16'hB4B5);
    chk(mb(32'h1806) == pat(32'h1806), "R8 unflushed byte kept", mb(32'h1806), pat(32'h1806));
    rd(3'd1, v); chk(v == 4, "R8 remaining count", v, 4);
    e = '{32'h1800, 32'h1804};
    chk_reqs(mark, e, "R8 R5");
    wr(3'd0, 32'h0);

    // R5 linear read across a 4 KB boundary, no list fetch
    for (int a = 32'hFFE; a <= 32'h1001; a++) exp_b.push_back(pat(32'(a)));
    mark = got_req.size();
    wr(3'd1, 4); wr(3'd2, 32'hFFE); wr(3'd3, 0); wr(3'd0, 32'h1);
    wait_stat(32'h4);
    chk(dptr == exp_b.size(), "R5 bytes delivered", dptr, exp_b.size());
    e = '{32'hFFC, 32'h1000};
    chk_reqs(mark, e, "R5");
    wr(3'd0, 32'h0);

    // R11 then R9
    mark = got_req.size();
    wr(3'd1, 20); wr(3'd2, 0); wr(3'd3, 32'h1000); wr(3'd0, 32'h5);
    repeat (3) @(negedge clk);
    wr(3'd1, 99); wr(3'd3, 32'h2000);
    rd(3'd1, v); chk(v == 20, "R11 count write ignored", v, 20);
    rd(3'd3, v); chk(v == 32'h1000, "R11 base write ignored", v, 32'h1000);
    wr(3'd0, 32'h6);
    chk(!mem_req && !dev_in_ready, "R9 stopped after abort", {mem_req, dev_in_ready}, 0);
    rd(3'd4, v); chk(v == 32'h12, "R9 abort status", v, 32'h12);
    rd(3'd1, v); chk(v == 20, "R9 count kept", v, 20);
    e = '{};
    chk_reqs(mark, e, "R9");
    wr(3'd0, 32'h0);

    // R10 error response
    mark = got_req.size();
    wr(3'd1, 8); wr(3'd2, 0); wr(3'd3, 32'h5000); wr(3'd0, 32'h1);
    wait_stat(32'h1);
    repeat (5) @(negedge clk);
    rd(3'd4, v); chk(v == 32'h11, "R10 error held", v, 32'h11);
    chk(!mem_req, "R10 no request after error", mem_req, 0);
    e = '{32'h5000};
    chk_reqs(mark, e, "R10");
    wr(3'd0, 32'h0);
    rd(3'd4, v); chk(v == 0, "R1 R10 idle clears error", v, 0);

    // R12 zero count
    mark = got_req.size();
    wr(3'd1, 0); wr(3'd0, 32'h1);
    repeat (3) @(negedge clk);
    rd(3'd4, v); chk(v == 32'h14, "R12 zero count done", v, 32'h14);
    e = '{};
    chk_reqs(mark, e, "R12");
    chk(dptr == exp_b.size(), "R6 no stray bytes", dptr, exp_b.size());

    $display("Simulation finished: %0d checks, %0d errors", checks + dchk, errors + derr);
    $finish;
  end
endmodule